// File: doc/BRIEF.md
# Return Address Stack with Checkpoint Repair

This block predicts where a return will land. The front end predicts control flow ahead of execution. A predicted call pushes the address of the instruction that follows the call. A predicted return pops the newest entry and presents it as the next fetch target. Because the structure is last-in-first-out, nested calls unwind in reverse order.

The front end predicts many branches before any of them resolves, so some pushes and pops happen on a path that turns out to be wrong. For this reason every predicted branch may save a checkpoint under a small tag. A checkpoint holds the top index, the occupancy and the value of the top entry, all as they stand after that cycle's push or pop. When a misprediction resolves, the front end restores the checkpoint by its tag. This removes the wrong-path activity, including a wrong-path push that overwrote the saved top slot.

Storage is a circular buffer. When a call arrives while the buffer is full, the oldest entry is overwritten and the depth stays at its maximum. A return on an empty stack produces no prediction. Asserting call and return in the same cycle is a protocol violation, which the block reports one cycle later.

Top module: `rasTop`

## Requirements
- R1: After reset the prediction valid and error outputs are low, the stack is empty, and every checkpoint slot holds the empty state.
- R2: A call pushes `callRetAddr`. A later return, with no other operation in between, raises `predValid` in the cycle after the return and drives that address on `predTarget`.
- R3: Nested calls are predicted in reverse order: the newest pushed address comes back first.
- R4: A return on an empty stack leaves `predValid` low. Whenever `predValid` is low, `predTarget` is all zeros.
- R5: The stack holds DEPTH (default 16) entries. A call on a full stack overwrites the oldest entry and leaves the depth at DEPTH. After DEPTH+1 calls, DEPTH returns predict the newest DEPTH addresses, and the next return is invalid.
- R6: `ckptAlloc` saves the top index, the depth and the top entry's value under `ckptTag` (0 to NUM_CKPT-1, default 8 tags). These values reflect any push or pop made in the same cycle.
- R7: `restoreValid` brings back the state saved under `restoreTag`. The top entry's value is restored even if a wrong-path push overwrote it. In a restore cycle, call, return and allocate requests are ignored, and the next cycle has `predValid` and `conflictErr` low.
- R8: Call and return in the same cycle (with no restore) leave the stack unchanged. `conflictErr` goes high in the next cycle and `predValid` stays low.
- R9: All NUM_CKPT checkpoints are held independently. Restoring one tag does not alter the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| callValid | input | 1 | Predicted call this cycle |
| callRetAddr | input | ADDR_W | Address after the call, to be pushed |
| retValid | input | 1 | Predicted return this cycle |
| ckptAlloc | input | 1 | Save a checkpoint this cycle |
| ckptTag | input | log2(NUM_CKPT) | Tag of the checkpoint to save |
| restoreValid | input | 1 | Misprediction repair this cycle |
| restoreTag | input | log2(NUM_CKPT) | Tag of the checkpoint to restore |
| predValid | output | 1 | Return prediction valid (registered) |
| predTarget | output | ADDR_W | Predicted return target, zero when invalid |
| conflictErr | output | 1 | Previous cycle requested call and return together |

## Verification
The hardest case to reach from the ports is a wrong-path push that overwrites the very slot that was the top entry at checkpoint time. Without the saved top value, the repaired stack would predict the wrong-path address. To reach it, the stimulus takes a checkpoint together with a call, pops that entry on the wrong path, and pushes a different address into the same slot. It then restores the checkpoint and unwinds the stack with returns. Further stimulus overflows the buffer through its wrap point, holds all eight tags live at once and restores them out of order. A behavioural queue model is compared against the outputs on every clock.

// File: rtl/rasPkg.sv
package rasPkg;
  // strobes from control to datapath for one clock
  typedef struct packed {
    logic push;     // write callRetAddr at the new top
    logic pop;      // valid pop: load prediction from current top
    logic save;     // record top value under ckptTag
    logic restore;  // rewrite the restored top slot from checkpoint
  } rasStrobeT;
endpackage

// File: rtl/rasCtrl.sv
module rasCtrl
  import rasPkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int NUM_CKPT = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int TAG_W   = $clog2(NUM_CKPT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callValid,
  input  logic             retValid,
  input  logic             ckptAlloc,
  input  logic [TAG_W-1:0] ckptTag,
  input  logic             restoreValid,
  input  logic [TAG_W-1:0] restoreTag,
  output rasStrobeT        strb,
  output logic [PTR_W-1:0] curPtr,
  output logic [PTR_W-1:0] nextPtr,
  output logic [CNT_W-1:0] stackCount,
  output logic             conflictErr
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] topPtr;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCnt;
  logic             conflictNow;
  logic [PTR_W-1:0] savedPtr [NUM_CKPT];
  logic [CNT_W-1:0] savedCnt [NUM_CKPT];

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] decPtr(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - PTR_W'(1);
  endfunction

  always_comb begin
    strb         = '0;
    conflictNow  = callValid && retValid && !restoreValid;
    strb.restore = restoreValid;
    strb.push    = callValid && !retValid && !restoreValid;
    strb.pop     = retValid && !callValid && !restoreValid && (count != '0);
    strb.save    = ckptAlloc && !restoreValid;
    nextPtr      = topPtr;
    nextCnt      = count;
    if (strb.restore) begin
      nextPtr = savedPtr[restoreTag];
      nextCnt = savedCnt[restoreTag];
    end else if (strb.push) begin
      nextPtr = incPtr(topPtr);
      nextCnt = (count == FULL_CNT) ? count : count + CNT_W'(1);
    end else if (strb.pop) begin
      nextPtr = decPtr(topPtr);
      nextCnt = count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr      <= '0;
      count       <= '0;
      conflictErr <= 1'b0;
    end else begin
      topPtr      <= nextPtr;
      count       <= nextCnt;
      conflictErr <= conflictNow;
    end
  end

  for (genvar i = 0; i < NUM_CKPT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        savedPtr[i] <= '0;
        savedCnt[i] <= '0;
      end else if (strb.save && (ckptTag == TAG_W'(i))) begin
        savedPtr[i] <= nextPtr;
        savedCnt[i] <= nextCnt;
      end
    end
  end

  assign curPtr     = topPtr;
  assign stackCount = count;
endmodule

// File: rtl/rasData.sv
module rasData
  import rasPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 16,
  parameter int NUM_CKPT = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int TAG_W   = $clog2(NUM_CKPT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasStrobeT         strb,
  input  logic [PTR_W-1:0]  curPtr,
  input  logic [PTR_W-1:0]  nextPtr,
  input  logic [TAG_W-1:0]  ckptTag,
  input  logic [TAG_W-1:0]  restoreTag,
  input  logic [ADDR_W-1:0] callRetAddr,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget
);
  logic [ADDR_W-1:0] entry   [DEPTH];
  logic [ADDR_W-1:0] savedTop [NUM_CKPT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
      predValid  <= 1'b0;
      predTarget <= '0;
    end else begin
      if (strb.push)         entry[nextPtr] <= callRetAddr;
      else if (strb.restore) entry[nextPtr] <= savedTop[restoreTag];
      predValid  <= strb.pop;
      predTarget <= strb.pop ? entry[curPtr] : '0;
    end
  end

  for (genvar i = 0; i < NUM_CKPT; i++) begin : g_top
    always_ff @(posedge clk) begin
      if (!rstN) begin
        savedTop[i] <= '0;
      end else if (strb.save && (ckptTag == TAG_W'(i))) begin
        savedTop[i] <= strb.push ? callRetAddr : entry[nextPtr];
      end
    end
  end
endmodule

// File: rtl/rasTop.sv
module rasTop
  import rasPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 16,
  parameter int NUM_CKPT = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int TAG_W   = $clog2(NUM_CKPT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callValid,
  input  logic [ADDR_W-1:0] callRetAddr,
  input  logic              retValid,
  input  logic              ckptAlloc,
  input  logic [TAG_W-1:0]  ckptTag,
  input  logic              restoreValid,
  input  logic [TAG_W-1:0]  restoreTag,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic              conflictErr
);
  rasStrobeT        strb;
  logic [PTR_W-1:0] curPtr;
  logic [PTR_W-1:0] nextPtr;
  logic [CNT_W-1:0] stackCount;

  rasCtrl #(.DEPTH(DEPTH), .NUM_CKPT(NUM_CKPT)) uCtrl (
    .clk(clk), .rstN(rstN), .callValid(callValid), .retValid(retValid),
    .ckptAlloc(ckptAlloc), .ckptTag(ckptTag), .restoreValid(restoreValid),
    .restoreTag(restoreTag), .strb(strb), .curPtr(curPtr), .nextPtr(nextPtr),
    .stackCount(stackCount), .conflictErr(conflictErr)
  );

  rasData #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .NUM_CKPT(NUM_CKPT)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .curPtr(curPtr), .nextPtr(nextPtr),
    .ckptTag(ckptTag), .restoreTag(restoreTag), .callRetAddr(callRetAddr),
    .predValid(predValid), .predTarget(predTarget)
  );
endmodule

// File: rtl/rasChecker.sv
module rasChecker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              callValid,
  input logic [ADDR_W-1:0] callRetAddr,
  input logic              retValid,
  input logic              restoreValid,
  input logic              predValid,
  input logic [ADDR_W-1:0] predTarget,
  input logic              conflictErr,
  input logic [CNT_W-1:0]  stackCount
);
  logic pushReq, popReq;
  assign pushReq = callValid && !retValid && !restoreValid;
  assign popReq  = retValid && !callValid && !restoreValid;

  // R2: push then immediate return predicts the pushed address
  p_push_pop_r2: assert property (@(posedge clk) disable iff (!rstN)
    pushReq ##1 popReq |=> predValid && (predTarget == $past(callRetAddr, 2)));

  // R4: empty return gives no prediction
  p_empty_ret_r4: assert property (@(posedge clk) disable iff (!rstN)
    popReq && (stackCount == '0) |=> !predValid);

  // R4: invalid prediction carries a zero target
  p_zero_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> (predTarget == '0));

  // R5: depth grows by one on a push and saturates at DEPTH
  p_push_depth_r5: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |=> stackCount == (($past(stackCount) == CNT_W'(DEPTH)) ?
                               $past(stackCount) : $past(stackCount) + CNT_W'(1)));

  p_depth_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    stackCount <= CNT_W'(DEPTH));

  // R7: restore cycle yields quiet outputs
  p_restore_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> !predValid && !conflictErr);

  // R8: same-cycle call and return flagged, depth untouched
  p_conflict_r8: assert property (@(posedge clk) disable iff (!rstN)
    callValid && retValid && !restoreValid |=>
      conflictErr && !predValid && $stable(stackCount));
endmodule

bind rasTop rasChecker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .callValid(callValid), .callRetAddr(callRetAddr),
  .retValid(retValid), .restoreValid(restoreValid), .predValid(predValid),
  .predTarget(predTarget), .conflictErr(conflictErr), .stackCount(stackCount)
);

// File: tb/tb_rasTop.sv
module tb_rasTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callValid = 1'b0;
  logic [31:0] callRetAddr = '0;
  logic        retValid = 1'b0;
  logic        ckptAlloc = 1'b0;
  logic [2:0]  ckptTag = '0;
  logic        restoreValid = 1'b0;
  logic [2:0]  restoreTag = '0;
  logic        predValid;
  logic [31:0] predTarget;
  logic        conflictErr;

  int errors = 0;
  int checks = 0;

  logic [31:0] model[$];
  logic [31:0] saved[8][$];
  logic        expValid;
  logic [31:0] expTarget;
  logic        expErr;

  always #5 clk = ~clk;

  rasTop dut (
    .clk(clk), .rstN(rstN), .callValid(callValid), .callRetAddr(callRetAddr),
    .retValid(retValid), .ckptAlloc(ckptAlloc), .ckptTag(ckptTag),
    .restoreValid(restoreValid), .restoreTag(restoreTag),
    .predValid(predValid), .predTarget(predTarget), .conflictErr(conflictErr)
  );

  task automatic compare(input string req);
    checks++;
    if (predValid !== expValid || predTarget !== expTarget || conflictErr !== expErr) begin
      errors++;
      $display("FAIL %s: got valid=%0b target=%h err=%0b, expected valid=%0b target=%h err=%0b",
               req, predValid, predTarget, conflictErr, expValid, expTarget, expErr);
    end
  endtask

  task automatic step(input logic c, input logic [31:0] a, input logic r,
                      input logic al, input int tg, input logic rs, input int rt,
                      input string req);
    @(negedge clk);
    callValid = c; callRetAddr = a; retValid = r;
    ckptAlloc = al; ckptTag = 3'(tg); restoreValid = rs; restoreTag = 3'(rt);
    expValid = 1'b0; expTarget = '0; expErr = 1'b0;
    if (rs) begin
      model = saved[rt];
    end else begin
      if (c && r) expErr = 1'b1;
      else if (c) begin
        model.push_back(a);
        if (model.size() > 16) void'(model.pop_front());
      end else if (r && model.size() > 0) begin
        expValid = 1'b1;
        expTarget = model.pop_back();
      end
      if (al) saved[tg] = model;
    end
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic call(input logic [31:0] a, input string req);
    step(1, a, 0, 0, 0, 0, 0, req);
  endtask

  task automatic ret(input string req);
    step(0, 0, 1, 0, 0, 0, 0, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expValid = 0; expTarget = 0; expErr = 0;
    compare("R1");
    ret("R1");                                   // empty after reset
    step(0, 0, 0, 0, 0, 1, 6, "R1");             // never-saved tag is empty
    ret("R1");

    // R2: single push and pop
    call(32'h0000_1004, "R2");
    ret("R2");

    // R3: nesting
    call(32'hA000_0010, "R3");
    call(32'hA000_0020, "R3");
    call(32'hA000_0030, "R3");
    ret("R3"); ret("R3");
    call(32'hA000_0040, "R3");
    ret("R3"); ret("R3");

    // R4: empty stack returns
    ret("R4"); ret("R4");

    // R5: overflow through the wrap point
    for (int i = 1; i <= 17; i++) call(32'hB000_0000 + i, "R5");
    for (int i = 0; i < 18; i++) ret("R5");

    // R6/R7: checkpoint with push, wrong path overwrites that top slot
    call(32'hC000_0001, "R6");
    call(32'hC000_0002, "R6");
    step(1, 32'hC000_0003, 0, 1, 2, 0, 0, "R6");
    ret("R7");                                    // wrong path pop
    call(32'hDEAD_0000, "R7");                    // wrong path overwrite
    step(1, 32'hDEAD_0001, 0, 0, 0, 1, 2, "R7");  // call ignored in restore
    ret("R7"); ret("R7"); ret("R7"); ret("R7");

    // R6: checkpoint taken with a pop in the same cycle
    call(32'hE000_0001, "R6");
    call(32'hE000_0002, "R6");
    step(0, 0, 1, 1, 4, 0, 0, "R6");
    call(32'hE0FF_0000, "R6");
    call(32'hE0FF_0001, "R6");
    step(0, 0, 0, 0, 0, 1, 4, "R6");
    ret("R6"); ret("R6");

    // R8: conflict leaves the stack alone
    call(32'hF000_0001, "R8");
    step(1, 32'hF000_0BAD, 1, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    ret("R8"); ret("R8");

    // R9: all eight tags live, restored out of order
    for (int t = 0; t < 8; t++) step(1, 32'h9000_0000 + t, 0, 1, t, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 5, "R9");
    ret("R9");
    step(0, 0, 0, 0, 0, 1, 1, "R9");
    ret("R9"); ret("R9");
    step(0, 0, 0, 0, 0, 1, 7, "R9");
    for (int i = 0; i < 9; i++) ret("R9");
    step(0, 0, 0, 0, 0, 1, 5, "R9");
    ret("R9");

    step(0, 0, 0, 0, 0, 0, 0, "R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule